// File: doc/BRIEF.md
# Time-Framed Ring Buffer Gatherer

This block takes a stream of variable-length events and packs them into a ring of persistent destination buffers. A frame timer starts when the first event lands in an empty buffer. The buffer is closed when that gathering window expires, when it is exactly full, or when the next event would not fit, whichever comes first. A closed buffer is reported to the host with one completion record, and the block then moves on to the next buffer in the ring. The number of buffers in use, the buffer size in data words, the window length and the ring base address are configuration inputs. They are held steady while the block is out of reset.

Every accepted data beat leaves as one write (address plus data) toward a DMA engine. An event never straddles two buffers. A closed buffer stays owned by the host until the host hands its index back. An event that finds its buffer still owned is discarded and counted, so overruns are visible rather than silent. An event longer than a whole buffer is also discarded and counted.

Top module: `tfg_gather`

## Requirements
- R1: Out of reset `wr_valid` and `cmp_valid` are low and `loss_count` is zero.
- R2: Each accepted beat produces exactly one write in the following cycle, carrying the beat's data unchanged. The write address is `cfg_base + idx*cfg_buf_words*BYTES + offset*BYTES`, where BYTES = DATA_W/8 and offset is the word position inside buffer `idx`.
- R3: If no event is in progress, `cmp_valid` rises exactly `cfg_gather`+1 cycles after the clock edge that accepted the buffer's first beat. Later events do not restart the window. If the window ends during an event, the close happens in the cycle after that event's last beat.
- R4: An event whose beat count (`s_len`+1, with `s_len` sampled on the head beat) would push a non-empty buffer past `cfg_buf_words` closes that buffer first. The whole event is then written from offset 0 of the next buffer.
- R5: A buffer filled to exactly `cfg_buf_words` closes at the next event boundary, without waiting for the window.
- R6: A completion carries the buffer index on `cmp_idx`, the byte count (words*BYTES) on `cmp_bytes` and the number of events on `cmp_events`. It is a one-cycle pulse.
- R7: Buffer indices advance 0,1,...,`cfg_nbuf`-1 and then wrap to 0, whose address is `cfg_base` again.
- R8: A closed buffer is owned by the host. An event that would start in an owned buffer produces no write and increments `loss_count` by one. Its remaining beats are consumed.
- R9: A `rel_valid` pulse clears ownership of buffer `rel_idx` only. After that the buffer accepts events again.
- R10: An event longer than `cfg_buf_words` beats produces no write, increments `loss_count` and does not close the open buffer.
- R11: `loss_count` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nbuf | input | IDX_W+1 | Buffers in use in the ring |
| cfg_buf_words | input | WORDS_W | Buffer size in data words |
| cfg_gather | input | TIMER_W | Gathering window in cycles |
| cfg_base | input | ADDR_W | Byte address of buffer 0 |
| s_valid | input | 1 | Event beat valid |
| s_data | input | DATA_W | Event beat data |
| s_len | input | LEN_W | Beats minus one, sampled on an event's head beat |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data |
| cmp_valid | output | 1 | Completion pulse |
| cmp_idx | output | IDX_W | Index of the closed buffer |
| cmp_bytes | output | WORDS_W+log2(DATA_W/8) | Bytes in the closed buffer |
| cmp_events | output | WORDS_W | Events in the closed buffer |
| rel_valid | input | 1 | Host returns a buffer |
| rel_idx | input | IDX_W | Index of the returned buffer |
| loss_count | output | LOSS_W | Dropped-event counter |

## Verification
A corrupted fill level shows up on the very next write as an address outside the expected word slot. It also shows up at the next completion as a wrong byte count or a wrong fit decision. A broken frame timer moves the completion pulse away from its exact cycle, so the bench measures the cycle distance from the first accepted beat for a sweep of window lengths. A lost or stuck ownership bit becomes visible at the next wrap of the ring: either an event is written into a buffer the host still holds, or the loss counter rises when it should not. Sweeps over every pair of short event lengths, and over each ring depth, expose these faults within a few cycles.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
   // Why the open buffer is being closed in the current cycle.
   typedef enum logic [1:0] {
      CLOSE_NONE = 2'd0,
      CLOSE_TIME = 2'd1,
      CLOSE_FULL = 2'd2,
      CLOSE_FIT  = 2'd3
   } close_cause_e;

   // What happens to an event head beat.
   typedef enum logic [1:0] {
      HEAD_NONE       = 2'd0,
      HEAD_TAKE       = 2'd1,
      HEAD_DROP_SIZE  = 2'd2,
      HEAD_DROP_OWNED = 2'd3
   } head_act_e;
endpackage

// File: rtl/tfg_frame_timer.sv
module tfg_frame_timer #(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               stop,
   input  logic [TIMER_W-1:0] limit,
   output logic               expired
);
   localparam logic [TIMER_W-1:0] CNT_MAX = '1;

   logic [TIMER_W-1:0] cnt_q;
   logic               run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (stop) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (run_q && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = run_q && (cnt_q >= limit);
endmodule

// File: rtl/tfg_own_table.sv
module tfg_own_table #(
   parameter int NBUF  = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   output logic [NBUF-1:0]  owned
);
   for (genvar i = 0; i < NBUF; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            owned[i] <= 1'b0;
         else if (set_en && set_idx == IDX_W'(i))
            owned[i] <= 1'b1;
         else if (clr_en && clr_idx == IDX_W'(i))
            owned[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/tfg_event_counter.sv
module tfg_event_counter #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            count <= '0;
         else if (inc && count != TOP)
            count <= count + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            count <= '0;
         else if (inc)
            count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/tfg_ring_cursor.sv
module tfg_ring_cursor #(
   parameter int IDX_W   = 2,
   parameter int WORDS_W = 8,
   parameter int ADDR_W  = 32,
   parameter int BYTE_SH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W:0]    cfg_nbuf,
   input  logic [WORDS_W-1:0] cfg_buf_words,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              advance,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [ADDR_W-1:0] cur_base,
   output logic [IDX_W-1:0]  nxt_idx,
   output logic [ADDR_W-1:0] nxt_base
);
   logic [ADDR_W-1:0] off_q, nxt_off, buf_bytes;
   logic              wrap;

   always_comb begin
      buf_bytes = ADDR_W'(cfg_buf_words) << BYTE_SH;
      wrap      = ({1'b0, cur_idx} + 1'b1) >= cfg_nbuf;
      nxt_idx   = wrap ? '0 : cur_idx + 1'b1;
      nxt_off   = wrap ? '0 : off_q + buf_bytes;
      cur_base  = cfg_base + off_q;
      nxt_base  = cfg_base + nxt_off;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx <= '0;
         off_q   <= '0;
      end else if (advance) begin
         cur_idx <= nxt_idx;
         off_q   <= nxt_off;
      end
   end
endmodule

// File: rtl/tfg_gather.sv
module tfg_gather
   import tfg_pkg::*;
#(
   parameter int DATA_W        = 64,
   parameter int ADDR_W        = 48,
   parameter int NBUF_MAX      = 8,
   parameter int WORDS_W       = 10,
   parameter int LEN_W         = 8,
   parameter int TIMER_W       = 20,
   parameter int LOSS_W        = 16,
   parameter bit LOSS_SATURATE = 1'b1,
   localparam int BYTES        = DATA_W / 8,
   localparam int BYTE_SH      = $clog2(BYTES),
   localparam int IDX_W        = $clog2(NBUF_MAX),
   localparam int BCNT_W       = WORDS_W + BYTE_SH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W:0]     cfg_nbuf,
   input  logic [WORDS_W-1:0] cfg_buf_words,
   input  logic [TIMER_W-1:0] cfg_gather,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic               s_valid,
   input  logic [DATA_W-1:0]  s_data,
   input  logic [LEN_W-1:0]   s_len,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [DATA_W-1:0]  wr_data,
   output logic               cmp_valid,
   output logic [IDX_W-1:0]   cmp_idx,
   output logic [BCNT_W-1:0]  cmp_bytes,
   output logic [WORDS_W-1:0] cmp_events,
   input  logic               rel_valid,
   input  logic [IDX_W-1:0]   rel_idx,
   output logic [LOSS_W-1:0]  loss_count
);
   localparam int SUM_W = ((WORDS_W > LEN_W + 1) ? WORDS_W : LEN_W + 1) + 1;

   // Elaboration-time parameter checks
   if (DATA_W < 8 || (DATA_W % 8) != 0 || (1 << BYTE_SH) != BYTES) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (NBUF_MAX < 2) begin : g_bad_nbuf
      $error("NBUF_MAX must be at least 2");
   end
   if (ADDR_W < BCNT_W + IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the ring");
   end
   if (TIMER_W < 1 || LOSS_W < 1 || LEN_W < 1 || WORDS_W < 1) begin : g_bad_w
      $error("widths must be positive");
   end

   logic [IDX_W-1:0]   cur_idx, nxt_idx, eff_idx;
   logic [ADDR_W-1:0]  cur_base, nxt_base, eff_base;
   logic [NBUF_MAX-1:0] owned;
   logic [WORDS_W-1:0] fill_q, ev_cnt_q, eff_fill;
   logic [LEN_W-1:0]   ev_rem_q;
   logic               ev_drop_q;
   logic               expired;

   logic               buf_open, at_bound, head, oversize, no_fit, full;
   logic               do_close, take_head, drop_head, beat_wr, blocked;
   logic [LEN_W:0]     len_beats;
   close_cause_e       cause;
   head_act_e          hact;

   always_comb begin
      buf_open  = (fill_q != '0);
      at_bound  = (ev_rem_q == '0);
      head      = s_valid && at_bound;
      len_beats = {1'b0, s_len} + 1'b1;
      oversize  = SUM_W'(len_beats) > SUM_W'(cfg_buf_words);
      no_fit    = (SUM_W'(fill_q) + SUM_W'(len_beats)) > SUM_W'(cfg_buf_words);
      full      = (fill_q == cfg_buf_words);

      cause = CLOSE_NONE;
      if (buf_open && at_bound) begin
         if (expired)                         cause = CLOSE_TIME;
         else if (full)                       cause = CLOSE_FULL;
         else if (head && !oversize && no_fit) cause = CLOSE_FIT;
      end
      do_close = (cause != CLOSE_NONE);

      eff_idx  = do_close ? nxt_idx  : cur_idx;
      eff_base = do_close ? nxt_base : cur_base;
      eff_fill = do_close ? '0       : fill_q;
      // a one-entry ring re-enters the buffer that is being handed over
      blocked  = owned[eff_idx] || (do_close && nxt_idx == cur_idx);

      hact = HEAD_NONE;
      if (head) begin
         if (oversize)     hact = HEAD_DROP_SIZE;
         else if (blocked) hact = HEAD_DROP_OWNED;
         else              hact = HEAD_TAKE;
      end
      take_head = (hact == HEAD_TAKE);
      drop_head = (hact == HEAD_DROP_SIZE) || (hact == HEAD_DROP_OWNED);
      beat_wr   = take_head || (s_valid && !at_bound && !ev_drop_q);
   end

   tfg_ring_cursor #(
      .IDX_W  (IDX_W),
      .WORDS_W(WORDS_W),
      .ADDR_W (ADDR_W),
      .BYTE_SH(BYTE_SH)
   ) u_cursor (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_nbuf     (cfg_nbuf),
      .cfg_buf_words(cfg_buf_words),
      .cfg_base     (cfg_base),
      .advance      (do_close),
      .cur_idx      (cur_idx),
      .cur_base     (cur_base),
      .nxt_idx      (nxt_idx),
      .nxt_base     (nxt_base)
   );

   tfg_own_table #(
      .NBUF (NBUF_MAX),
      .IDX_W(IDX_W)
   ) u_own (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (do_close),
      .set_idx(cur_idx),
      .clr_en (rel_valid),
      .clr_idx(rel_idx),
      .owned  (owned)
   );

   tfg_frame_timer #(
      .TIMER_W(TIMER_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (take_head && eff_fill == '0),
      .stop   (do_close),
      .limit  (cfg_gather),
      .expired(expired)
   );

   tfg_event_counter #(
      .W       (LOSS_W),
      .SATURATE(LOSS_SATURATE)
   ) u_loss (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (drop_head),
      .count(loss_count)
   );

   // Event tracking and fill level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_rem_q  <= '0;
         ev_drop_q <= 1'b0;
         fill_q    <= '0;
         ev_cnt_q  <= '0;
      end else begin
         if (head) begin
            ev_rem_q  <= s_len;
            ev_drop_q <= drop_head;
         end else if (s_valid) begin
            ev_rem_q  <= ev_rem_q - 1'b1;
         end
         fill_q   <= eff_fill + WORDS_W'(beat_wr);
         ev_cnt_q <= (do_close ? '0 : ev_cnt_q) + WORDS_W'(take_head);
      end
   end

   // Write port toward the DMA engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= beat_wr;
         if (beat_wr) begin
            wr_addr <= eff_base + (ADDR_W'(eff_fill) << BYTE_SH);
            wr_data <= s_data;
         end
      end
   end

   // Completion record
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_valid  <= 1'b0;
         cmp_idx    <= '0;
         cmp_bytes  <= '0;
         cmp_events <= '0;
      end else begin
         cmp_valid <= do_close;
         if (do_close) begin
            cmp_idx    <= cur_idx;
            cmp_bytes  <= BCNT_W'(fill_q) << BYTE_SH;
            cmp_events <= ev_cnt_q;
         end
      end
   end
endmodule

// File: rtl/tfg_gather_chk.sv
module tfg_gather_chk #(
   parameter int ADDR_W  = 48,
   parameter int IDX_W   = 3,
   parameter int WORDS_W = 10,
   parameter int BCNT_W  = 13,
   parameter int BYTES   = 8,
   parameter int LOSS_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [IDX_W:0]     cfg_nbuf,
   input logic [WORDS_W-1:0] cfg_buf_words,
   input logic [ADDR_W-1:0]  cfg_base,
   input logic               wr_valid,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic               cmp_valid,
   input logic [IDX_W-1:0]   cmp_idx,
   input logic [BCNT_W-1:0]  cmp_bytes,
   input logic [WORDS_W-1:0] cmp_events,
   input logic [LOSS_W-1:0]  loss_count
);
   localparam int EW = ADDR_W + IDX_W + WORDS_W + 8;

   logic [EW-1:0] ring_lo, ring_hi, buf_bytes;
   always_comb begin
      buf_bytes = EW'(cfg_buf_words) * EW'(BYTES);
      ring_lo   = EW'(cfg_base);
      ring_hi   = ring_lo + EW'(cfg_nbuf) * buf_bytes;
   end

   // R2
   wr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (EW'(wr_addr) >= ring_lo && EW'(wr_addr) < ring_hi));

   // R5
   cmp_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> EW'(cmp_bytes) <= buf_bytes);

   // R6
   cmp_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> (cmp_events != '0 && EW'(cmp_events) * EW'(BYTES) <= EW'(cmp_bytes)));

   // R7
   cmp_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cfg_nbuf != '0) |-> ({1'b0, cmp_idx} < cfg_nbuf));

   // R8
   loss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loss_count == $past(loss_count)) || (loss_count == $past(loss_count) + 1'b1));

   // R11
   loss_hold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&$past(loss_count)) |-> (&loss_count));
endmodule

bind tfg_gather tfg_gather_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W),
   .WORDS_W(WORDS_W),
   .BCNT_W (BCNT_W),
   .BYTES  (BYTES),
   .LOSS_W (LOSS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_nbuf     (cfg_nbuf),
   .cfg_buf_words(cfg_buf_words),
   .cfg_base     (cfg_base),
   .wr_valid     (wr_valid),
   .wr_addr      (wr_addr),
   .cmp_valid    (cmp_valid),
   .cmp_idx      (cmp_idx),
   .cmp_bytes    (cmp_bytes),
   .cmp_events   (cmp_events),
   .loss_count   (loss_count)
);

// File: tb/tfg_gather_tb.sv
module tfg_gather_tb;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 32;
   localparam int NBUF   = 4;
   localparam int WW     = 4;
   localparam int LW     = 4;
   localparam int TW     = 8;
   localparam int LOSSW  = 3;
   localparam int BASE   = 32'h1000;
   localparam int LOGN   = 1024;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        cfg_nbuf = 3'd4;
   logic [WW-1:0]     cfg_buf_words = 4'd8;
   logic [TW-1:0]     cfg_gather = 8'd10;
   logic [ADDR_W-1:0] cfg_base = BASE;
   logic              s_valid = 1'b0;
   logic [DATA_W-1:0] s_data = '0;
   logic [LW-1:0]     s_len = '0;
   logic              wr_valid;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              cmp_valid;
   logic [1:0]        cmp_idx;
   logic [5:0]        cmp_bytes;
   logic [WW-1:0]     cmp_events;
   logic              rel_valid = 1'b0;
   logic [1:0]        rel_idx = '0;
   logic [LOSSW-1:0]  loss_count;

   tfg_gather #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBUF_MAX(NBUF), .WORDS_W(WW),
      .LEN_W(LW), .TIMER_W(TW), .LOSS_W(LOSSW), .LOSS_SATURATE(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_nbuf(cfg_nbuf), .cfg_buf_words(cfg_buf_words),
      .cfg_gather(cfg_gather), .cfg_base(cfg_base), .s_valid(s_valid), .s_data(s_data),
      .s_len(s_len), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_bytes(cmp_bytes),
      .cmp_events(cmp_events), .rel_valid(rel_valid), .rel_idx(rel_idx),
      .loss_count(loss_count)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // Output logs, sampled at the falling edge
   logic [31:0] wl_addr [LOGN];
   logic [31:0] wl_data [LOGN];
   int          cl_idx  [LOGN];
   int          cl_bytes[LOGN];
   int          cl_ev   [LOGN];
   int          cl_cyc  [LOGN];
   int          wn = 0;
   int          cn = 0;
   always @(negedge clk) begin
      if (wr_valid && wn < LOGN) begin
         wl_addr[wn] <= wr_addr;
         wl_data[wn] <= wr_data;
         wn <= wn + 1;
      end
      if (cmp_valid && cn < LOGN) begin
         cl_idx[cn]   <= int'(cmp_idx);
         cl_bytes[cn] <= int'(cmp_bytes);
         cl_ev[cn]    <= int'(cmp_events);
         cl_cyc[cn]   <= cyc;
         cn <= cn + 1;
      end
   end

   int checks = 0;
   int failures = 0;
   int wb = 0;
   int cb = 0;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int nbuf, input int words, input int gather);
      rst_n = 1'b0;
      s_valid = 1'b0;
      rel_valid = 1'b0;
      cfg_nbuf = 3'(nbuf);
      cfg_buf_words = WW'(words);
      cfg_gather = TW'(gather);
      cfg_base = BASE;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1;
      wb = wn;
      cb = cn;
   endtask

   task automatic send(input int len, input int tag, output int acc);
      acc = 0;
      for (int i = 0; i < len; i++) begin
         s_valid = 1'b1;
         s_len = LW'(len - 1);
         s_data = {8'(tag), 8'(i), 16'hC0DE};
         @(posedge clk);
         #1;
         if (i == 0) acc = cyc;
      end
      s_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic give_back(input int idx);
      rel_valid = 1'b1;
      rel_idx = 2'(idx);
      @(posedge clk);
      #1;
      rel_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
   end

   initial begin : main
      int a0, a1, exp_cn, fill, addr_b, first_bytes;

      // R1: reset state
      do_reset(4, 8, 10);
      chk("R1 wr_valid", wr_valid, 0);
      chk("R1 cmp_valid", cmp_valid, 0);
      chk("R1 loss_count", loss_count, 0);

      // R3/R6/R2: window length sweep with one single-beat event
      for (int g = 0; g <= 6; g++) begin
         do_reset(4, 8, g);
         send(1, 16 + g, a0);
         idle(g + 4);
         chk("R3 completion count", cn - cb, 1);
         chk("R3 completion cycle", cl_cyc[cb], a0 + g + 1);
         chk("R6 idx", cl_idx[cb], 0);
         chk("R6 bytes", cl_bytes[cb], 4);
         chk("R6 events", cl_ev[cb], 1);
         chk("R2 addr", wl_addr[wb], BASE);
         chk("R2 data", wl_data[wb], {8'(16 + g), 8'd0, 16'hC0DE});
      end

      // R3/R6: two events in one window, timer not restarted
      do_reset(4, 8, 10);
      send(1, 1, a0);
      idle(2);
      send(2, 2, a1);
      idle(20);
      chk("R3 multi-event count", cn - cb, 1);
      chk("R3 window from first event", cl_cyc[cb], a0 + 11);
      chk("R6 multi bytes", cl_bytes[cb], 12);
      chk("R6 multi events", cl_ev[cb], 2);
      chk("R2 second event addr", wl_addr[wb + 1], BASE + 4);
      chk("R2 second event beat1 addr", wl_addr[wb + 2], BASE + 8);

      // R3: window ends inside an event
      do_reset(4, 8, 1);
      send(5, 3, a0);
      idle(6);
      chk("R3 mid-event close cycle", cl_cyc[cb], a0 + 5);
      chk("R3 mid-event bytes", cl_bytes[cb], 20);

      // R4/R5: every pair of lengths into a four-word buffer
      for (int a = 1; a <= 4; a++) begin
         for (int b = 1; b <= 4; b++) begin
            do_reset(4, 4, 200);
            send(a, 32 + a, a0);
            send(b, 48 + b, a1);
            idle(4);
            exp_cn = 0;
            fill = 0;
            first_bytes = 0;
            addr_b = 0;
            for (int k = 0; k < 2; k++) begin
               int l;
               l = (k == 0) ? a : b;
               if (fill > 0 && fill + l > 4) begin
                  if (exp_cn == 0) first_bytes = fill * 4;
                  exp_cn++;
                  fill = 0;
               end
               if (k == 1) addr_b = BASE + exp_cn * 16 + fill * 4;
               fill += l;
               if (fill == 4) begin
                  if (exp_cn == 0) first_bytes = 16;
                  exp_cn++;
                  fill = 0;
               end
            end
            chk("R4 completions", cn - cb, exp_cn);
            chk("R4 second event start addr", wl_addr[wb + a], addr_b);
            chk("R2 second event data", wl_data[wb + a], {8'(48 + b), 8'd0, 16'hC0DE});
            if (exp_cn > 0) chk("R5 first close bytes", cl_bytes[cb], first_bytes);
         end
      end

      // R7/R8/R9: ring depth sweep with one-word buffers
      for (int n = 1; n <= 4; n++) begin
         do_reset(n, 1, 200);
         for (int i = 0; i < n; i++) send(1, 64 + i, a0);
         idle(3);
         chk("R7 closes", cn - cb, n);
         for (int i = 0; i < n; i++) begin
            chk("R7 idx order", cl_idx[cb + i], i);
            chk("R7 buffer addr", wl_addr[wb + i], BASE + 4 * i);
         end
         send(1, 80, a0);
         idle(3);
         chk("R8 owned drop loss", loss_count, 1);
         chk("R8 owned drop no write", wn - wb, n);
         if (n > 1) begin
            give_back(n - 1);
            send(1, 81, a0);
            idle(3);
            chk("R9 other release keeps owner", loss_count, 2);
            chk("R9 no write after other release", wn - wb, n);
         end
         give_back(0);
         send(1, 82, a0);
         idle(3);
         chk("R9 write after release", wn - wb, n + 1);
         chk("R7 wrap addr", wl_addr[wb + n], BASE);
         chk("R7 wrap idx", cl_idx[cn - 1], 0);
      end

      // R10: oversize events
      do_reset(4, 4, 200);
      send(5, 90, a0);
      idle(2);
      chk("R10 oversize loss", loss_count, 1);
      chk("R10 oversize no write", wn - wb, 0);
      send(2, 91, a0);
      send(6, 92, a0);
      idle(2);
      chk("R10 open buffer kept", cn - cb, 0);
      chk("R10 loss second", loss_count, 2);
      send(2, 93, a0);
      idle(3);
      chk("R10 close after refill", cn - cb, 1);
      chk("R10 bytes", cl_bytes[cb], 16);
      chk("R10 events", cl_ev[cb], 2);
      chk("R10 writes", wn - wb, 4);

      // R11: saturation
      do_reset(4, 2, 200);
      for (int i = 0; i < 9; i++) send(3, 100, a0);
      idle(2);
      chk("R11 loss saturates", loss_count, 7);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule